// File: doc/BRIEF.md
# Outer Bank Register File

This block keeps four 8-bit outer banking registers for a cartridge mapper that also contains an inner bank controller. The CPU writes these registers through a 4 KiB decode window. A strap input chooses where that window sits: in the $6000 page or in the $5000 page. The two lowest CPU address bits pick one of the four registers, so the set repeats across the whole window. The register contents go straight out to the PRG and CHR address composers. A one-cycle recompute strobe tells those composers to refresh their mappings after each write that changes a register.

Register 3 also acts as the control byte. When its lock bit is set and its fixed-bank mode bit is clear, every later register write is refused. This holds until a reset clears the file. Independently of the registers, any CPU write that lands in either the $5000 or the $6000 page is forwarded to work RAM while the inner controller's RAM-enable bit is high. That forwarding happens whatever the strap and the lock state are.

Top module: `obr_regfile`

## Requirements
- R1: While `rst_n` is low and after it is released, `bank_regs` is all zero and `recompute_stb` and `wram_we` are low. Register n occupies `bank_regs[8n+7:8n]`.
- R2: A clock edge with `cpu_reset` high clears all four registers to zero. No register write is accepted in that cycle.
- R3: An accepted write stores `cpu_wdata` into the register numbered `cpu_addr[1:0]`. Bits 11:2 of the address are ignored, so the registers repeat every 4 bytes across the window. The new value is visible after the same clock edge that samples the write.
- R4: With `win_strap` = 0, the registers answer to `cpu_addr[15:12]` = 4'h6. A write to the 4'h5 page leaves every register unchanged.
- R5: With `win_strap` = 1, the registers answer to `cpu_addr[15:12]` = 4'h5. A write to the 4'h6 page leaves every register unchanged.
- R6: While register 3 has bit 7 = 1 and bit 4 = 0, register writes are refused. This includes writes to register 3 itself. All registers stay unchanged and no recompute strobe follows.
- R7: While register 3 bit 4 = 1, bit 7 has no locking effect and writes are accepted.
- R8: A CPU write to page 4'h5 or 4'h6 while `ram_en` = 1 raises `wram_we` for exactly the next cycle. In that cycle `wram_addr` and `wram_wdata` hold the written address and data. This happens regardless of strap, lock and `cpu_reset`. With `ram_en` = 0 there is no pulse.
- R9: `recompute_stb` is high for exactly one cycle, one cycle after the register update caused by an accepted write. A refused or out-of-window write produces no pulse.
- R10: A write outside pages 4'h5 and 4'h6 changes no register and causes neither `wram_we` nor `recompute_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cpu_reset | input | 1 | Synchronous console reset, clears the registers |
| cpu_wr_en | input | 1 | One-cycle CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| win_strap | input | 1 | Window placement: 0 = $6000 page, 1 = $5000 page |
| ram_en | input | 1 | Work-RAM enable from the inner controller |
| bank_regs | output | 32 | Four registers, register n at bits 8n+7:8n |
| recompute_stb | output | 1 | One-cycle mapping-refresh pulse |
| wram_we | output | 1 | Work-RAM write pulse |
| wram_addr | output | 16 | Work-RAM write address |
| wram_wdata | output | 8 | Work-RAM write data |

## Verification
Two things can happen from one CPU write: a register update and a work-RAM write. The bench issues writes to the register page with `ram_en` high and checks that `wram_we` rises in the same cycle that the new register value appears. The recompute strobe should then follow one cycle later. It repeats this with the block locked and with the strap pointing at the other page. There, only the work-RAM pulse may appear, while `bank_regs` holds its value and no strobe is seen.

// File: rtl/obr_pkg.sv
package obr_pkg;
    localparam int OBR_DATA_W   = 8;
    localparam int OBR_ADDR_W   = 16;
    localparam int OBR_NUM_REGS = 4;
    localparam int OBR_PAGE_W   = 4;

    typedef enum logic {
        WIN_HIGH_PAGE = 1'b0,
        WIN_LOW_PAGE  = 1'b1
    } win_place_e;
endpackage

// File: rtl/obr_decode.sv
module obr_decode #(
    parameter int PAGE_W  = 4,
    parameter int PAGE_LO = 5,
    parameter int PAGE_HI = 6
) (
    input  logic [PAGE_W-1:0] page,
    input  logic              strap,
    output logic              reg_hit,
    output logic              wram_hit
);
    import obr_pkg::*;

    localparam logic [PAGE_W-1:0] LO_P = PAGE_W'(PAGE_LO);
    localparam logic [PAGE_W-1:0] HI_P = PAGE_W'(PAGE_HI);

    logic [PAGE_W-1:0] reg_page;

    always_comb begin
        reg_page = (win_place_e'(strap) == WIN_LOW_PAGE) ? LO_P : HI_P;
        reg_hit  = (page == reg_page);
        wram_hit = (page == LO_P) || (page == HI_P);
    end
endmodule

// File: rtl/obr_lock.sv
module obr_lock (
    input  logic lock_bit,
    input  logic mode_bit,
    output logic locked
);
    // Lock only bites while the fixed-bank mode bit is clear.
    always_comb locked = lock_bit & ~mode_bit;
endmodule

// File: rtl/obr_regfile.sv
module obr_regfile #(
    parameter int DATA_W   = obr_pkg::OBR_DATA_W,
    parameter int ADDR_W   = obr_pkg::OBR_ADDR_W,
    parameter int NUM_REGS = obr_pkg::OBR_NUM_REGS,
    parameter int PAGE_W   = obr_pkg::OBR_PAGE_W,
    parameter int PAGE_LO  = 5,
    parameter int PAGE_HI  = 6,
    parameter int CTRL_REG = 3,
    parameter int LOCK_BIT = 7,
    parameter int MODE_BIT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_reset,
    input  logic                       cpu_wr_en,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic [DATA_W-1:0]          cpu_wdata,
    input  logic                       win_strap,
    input  logic                       ram_en,
    output logic [NUM_REGS*DATA_W-1:0] bank_regs,
    output logic                       recompute_stb,
    output logic                       wram_we,
    output logic [ADDR_W-1:0]          wram_addr,
    output logic [DATA_W-1:0]          wram_wdata
);
    localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic                            accept;
        logic                            recompute;
        logic                            wram_we;
        logic [ADDR_W-1:0]               wram_addr;
        logic [DATA_W-1:0]               wram_wdata;
    } state_t;

    state_t st_d, st_q;

    logic             reg_hit, wram_hit, locked, write_ok;
    logic [SEL_W-1:0] sel;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_next;

    assign sel = cpu_addr[SEL_W-1:0];

    obr_decode #(
        .PAGE_W (PAGE_W),
        .PAGE_LO(PAGE_LO),
        .PAGE_HI(PAGE_HI)
    ) decode_i (
        .page    (cpu_addr[ADDR_W-1 -: PAGE_W]),
        .strap   (win_strap),
        .reg_hit (reg_hit),
        .wram_hit(wram_hit)
    );

    obr_lock lock_i (
        .lock_bit(st_q.regs[CTRL_REG][LOCK_BIT]),
        .mode_bit(st_q.regs[CTRL_REG][MODE_BIT]),
        .locked  (locked)
    );

    assign write_ok = cpu_wr_en & reg_hit & ~locked & ~cpu_reset;

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        always_comb begin
            if (cpu_reset)
                regs_next[gi] = '0;
            else if (write_ok && (sel == SEL_W'(gi)))
                regs_next[gi] = cpu_wdata;
            else
                regs_next[gi] = st_q.regs[gi];
        end
    end

    always_comb begin
        st_d           = st_q;
        st_d.regs      = regs_next;
        st_d.accept    = write_ok;
        st_d.recompute = st_q.accept;
        st_d.wram_we   = cpu_wr_en & wram_hit & ram_en;
        if (cpu_wr_en & wram_hit & ram_en) begin
            st_d.wram_addr  = cpu_addr;
            st_d.wram_wdata = cpu_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign bank_regs     = st_q.regs;
    assign recompute_stb = st_q.recompute;
    assign wram_we       = st_q.wram_we;
    assign wram_addr     = st_q.wram_addr;
    assign wram_wdata    = st_q.wram_wdata;
endmodule

// File: rtl/obr_regfile_chk.sv
module obr_regfile_chk #(
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 16,
    parameter int NUM_REGS = 4,
    parameter int PAGE_W   = 4,
    parameter int PAGE_LO  = 5,
    parameter int PAGE_HI  = 6,
    parameter int CTRL_REG = 3,
    parameter int LOCK_BIT = 7,
    parameter int MODE_BIT = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cpu_reset,
    input logic                       cpu_wr_en,
    input logic [ADDR_W-1:0]          cpu_addr,
    input logic [DATA_W-1:0]          cpu_wdata,
    input logic                       win_strap,
    input logic                       ram_en,
    input logic [NUM_REGS*DATA_W-1:0] bank_regs,
    input logic                       recompute_stb,
    input logic                       wram_we,
    input logic [ADDR_W-1:0]          wram_addr,
    input logic [DATA_W-1:0]          wram_wdata
);
    logic [PAGE_W-1:0] pg;
    logic              in_any, in_regs, lk;

    assign pg      = cpu_addr[ADDR_W-1 -: PAGE_W];
    assign in_any  = (pg == PAGE_W'(PAGE_LO)) || (pg == PAGE_W'(PAGE_HI));
    assign in_regs = (pg == (win_strap ? PAGE_W'(PAGE_LO) : PAGE_W'(PAGE_HI)));
    assign lk      = bank_regs[CTRL_REG*DATA_W+LOCK_BIT] & ~bank_regs[CTRL_REG*DATA_W+MODE_BIT];

    // R2
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset |=> (bank_regs == '0));

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk && !cpu_reset) |=> $stable(bank_regs));

    // R9
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_en && in_regs && !lk && !cpu_reset) |=> ##1 recompute_stb);

    // R8
    wram_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_en && in_any && ram_en) |=>
            (wram_we && wram_addr == $past(cpu_addr) && wram_wdata == $past(cpu_wdata)));

    // R10
    outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cpu_wr_en && in_any) && !cpu_reset) |=> (!wram_we && $stable(bank_regs)));
endmodule

bind obr_regfile obr_regfile_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .PAGE_W(PAGE_W),
    .PAGE_LO(PAGE_LO), .PAGE_HI(PAGE_HI), .CTRL_REG(CTRL_REG),
    .LOCK_BIT(LOCK_BIT), .MODE_BIT(MODE_BIT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cpu_reset(cpu_reset), .cpu_wr_en(cpu_wr_en),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .win_strap(win_strap),
    .ram_en(ram_en), .bank_regs(bank_regs), .recompute_stb(recompute_stb),
    .wram_we(wram_we), .wram_addr(wram_addr), .wram_wdata(wram_wdata)
);

// File: tb/obr_regfile_tb.sv
module obr_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_reset = 1'b0;
    logic        cpu_wr_en = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        win_strap = 1'b0;
    logic        ram_en = 1'b0;
    logic [31:0] bank_regs;
    logic        recompute_stb, wram_we;
    logic [15:0] wram_addr;
    logic [7:0]  wram_wdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] got_regs;
    logic        got_wram, got_rec, got_rec2;
    logic [15:0] got_waddr;
    logic [7:0]  got_wdata;

    always #2 clk = ~clk;

    obr_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_reset(cpu_reset), .cpu_wr_en(cpu_wr_en),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .win_strap(win_strap),
        .ram_en(ram_en), .bank_regs(bank_regs), .recompute_stb(recompute_stb),
        .wram_we(wram_we), .wram_addr(wram_addr), .wram_wdata(wram_wdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One write: inputs set at a falling edge, results sampled at the following falling edges.
    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr_en = 1'b1;
        @(negedge clk);
        cpu_wr_en = 1'b0;
        got_regs  = bank_regs;
        got_wram  = wram_we;
        got_waddr = wram_addr;
        got_wdata = wram_wdata;
        got_rec   = recompute_stb;
        @(negedge clk);
        got_rec2  = recompute_stb;
        @(negedge clk);
    endtask

    task automatic sync_clear();
        cpu_reset = 1'b1;
        @(negedge clk);
        cpu_reset = 1'b0;
        chk(bank_regs == 32'h0, "R2 sync clear", bank_regs, 32'h0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(bank_regs == 32'h0 && !recompute_stb && !wram_we, "R1 in reset", {bank_regs[30:0], recompute_stb}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bank_regs == 32'h0 && !recompute_stb && !wram_we, "R1 after release", bank_regs, 32'h0);
    endtask

    task automatic t_select_mirror();
        win_strap = 1'b0;
        ram_en    = 1'b0;
        do_write(16'h6000, 8'h11);
        chk(got_regs[7:0] == 8'h11, "R3 reg0", got_regs, 32'h11);
        chk(!got_rec && got_rec2, "R9 strobe timing", {got_rec, got_rec2}, 2'b01);
        do_write(16'h6FFD, 8'h22);
        chk(got_regs == 32'h0000_2211, "R3 mirror reg1", got_regs, 32'h0000_2211);
        do_write(16'h6A46, 8'h33);
        chk(got_regs == 32'h0033_2211, "R3 mirror reg2", got_regs, 32'h0033_2211);
        @(negedge clk);
        chk(!recompute_stb, "R9 single pulse", recompute_stb, 0);
    endtask

    task automatic t_strap();
        win_strap = 1'b0;
        do_write(16'h5000, 8'hAA);
        chk(got_regs == 32'h0033_2211, "R4 low page ignored", got_regs, 32'h0033_2211);
        chk(!got_rec2, "R9 no strobe on ignored", got_rec2, 0);
        win_strap = 1'b1;
        do_write(16'h6000, 8'hBB);
        chk(got_regs == 32'h0033_2211, "R5 high page ignored", got_regs, 32'h0033_2211);
        do_write(16'h5FF0, 8'h44);
        chk(got_regs == 32'h0033_2244, "R5 low page accepted", got_regs, 32'h0033_2244);
        win_strap = 1'b0;
    endtask

    task automatic t_outside();
        ram_en = 1'b1;
        do_write(16'h7001, 8'h99);
        chk(got_regs == 32'h0033_2244 && !got_wram && !got_rec2, "R10 outside",
            {got_regs[29:0], got_wram, got_rec2}, {30'h0033_2244, 2'b00});
        do_write(16'h4FFF, 8'h99);
        chk(!got_wram && got_regs == 32'h0033_2244, "R10 below window", got_wram, 0);
    endtask

    task automatic t_wram_overlap();
        ram_en = 1'b1;
        do_write(16'h6003, 8'h5C);
        chk(got_wram && got_regs[31:24] == 8'h5C, "R8 same cycle reg+wram", {got_wram, got_regs[31:24]}, 9'h15C);
        chk(got_waddr == 16'h6003 && got_wdata == 8'h5C, "R8 addr data", {got_waddr, got_wdata}, 24'h60035C);
        chk(got_rec2, "R9 strobe after overlap", got_rec2, 1);
        do_write(16'h5123, 8'h77);
        chk(got_wram && got_waddr == 16'h5123 && got_regs[31:24] == 8'h5C, "R8 other page wram only",
            {got_wram, got_waddr}, 17'h15123);
        ram_en = 1'b0;
        do_write(16'h6002, 8'h66);
        chk(!got_wram && got_regs[23:16] == 8'h66, "R8 ram_en low", got_wram, 0);
        @(negedge clk);
        chk(!wram_we, "R8 single pulse", wram_we, 0);
    endtask

    task automatic t_lock();
        sync_clear();
        do_write(16'h6003, 8'h80);
        chk(got_regs == 32'h8000_0000, "R6 lock set", got_regs, 32'h8000_0000);
        ram_en = 1'b1;
        do_write(16'h6000, 8'h55);
        chk(got_regs == 32'h8000_0000 && !got_rec2, "R6 write refused", got_regs, 32'h8000_0000);
        chk(got_wram, "R8 wram while locked", got_wram, 1);
        do_write(16'h6003, 8'h00);
        chk(got_regs == 32'h8000_0000, "R6 ctrl refused", got_regs, 32'h8000_0000);
        sync_clear();
        do_write(16'h6003, 8'h90);
        do_write(16'h6000, 8'h33);
        chk(got_regs == 32'h9000_0033 && got_rec2, "R7 mode bit unlocks", got_regs, 32'h9000_0033);
        ram_en = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_select_mirror();
        t_strap();
        t_outside();
        t_wram_overlap();
        t_lock();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule